// File: doc/BRIEF.md
# Basic Interval and Watchdog Timer

This block is an 8-bit free-running divider. It advances on one of four prescaled tick strobes, which come from a system-clock prescaler outside the block. A small mode register picks the strobe. Each time the divider wraps from its top value to zero, the block raises a sticky interrupt flag and sends a one-cycle request to the interrupt controller. In the same cycle it sends a one-cycle wake strobe, which tells standby logic that the oscillator-settling wait is over.

Software uses the block in one of three ways: as a periodic time base, as a wait counter after standby exit, or as a watchdog. For the watchdog case, a separate timeout strobe fires when a wrap happens while the flag from the previous wrap is still set, which means software has not serviced it. One write-only bit in the mode register clears both the divider and the flag. The current divider value and the selector field can be read back at any time.

Top module: `bit_timer`

## Requirements
- R1: During reset (`rst` high, sampled on the rising clock edge) and after it, `count_q` is 0, `irq_flag`, `irq_req`, `wait_release` and `wdt_timeout` are 0, and `mode_rdata` is 0. The reset selector value 000 selects the slowest tick.
- R2: `mode_wdata[2:0]` selects the tick input. Code 111 selects `tap_tick[0]` (clock/2^5), 101 selects `tap_tick[1]` (clock/2^7), 011 selects `tap_tick[2]` (clock/2^9) and 000 selects `tap_tick[3]` (clock/2^12).
- R3: Selector codes 001, 010, 100 and 110 stop the divider. `count_q` then holds whatever the tick inputs do.
- R4: Each cycle with the selected tick high adds exactly one to `count_q`. Tick strobes on inputs that are not selected have no effect.
- R5: A selected tick while `count_q` is 255 wraps it to 0. In the cycle after that tick, `irq_flag` becomes 1 and `irq_req` is high for exactly one cycle.
- R6: `wait_release` pulses high for one cycle, in the same cycle as `irq_req`, on every wrap.
- R7: A mode write with `mode_wdata[3]` = 1 sets `count_q` and `irq_flag` to 0 from the next cycle. A write with bit 3 = 0 changes only the selector and leaves `count_q` unchanged.
- R8: A clear write takes priority over a wrap in the same cycle. The result is `count_q` 0 and `irq_flag` 0, with no `irq_req`, `wait_release` or `wdt_timeout` pulse.
- R9: `mode_rdata[2:0]` returns the last written selector, and `mode_rdata[3]` always reads 0.
- R10: `wdt_timeout` pulses for one cycle, together with `irq_req`, on a wrap that finds `irq_flag` already 1. It stays 0 on a wrap that finds the flag clear.
- R11: Once set, `irq_flag` stays at 1 through later cycles until a clear write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_tick | input | 4 | Prescaler tick strobes: bit0 = /2^5, bit1 = /2^7, bit2 = /2^9, bit3 = /2^12 |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode write data; [2:0] selector, [3] clear |
| mode_rdata | output | 4 | Mode readback; bit 3 always 0 |
| count_q | output | 8 | Current divider value |
| irq_flag | output | 1 | Sticky interrupt request flag |
| irq_req | output | 1 | One-cycle interrupt request on wrap |
| wait_release | output | 1 | One-cycle standby wait-release strobe on wrap |
| wdt_timeout | output | 1 | One-cycle watchdog timeout strobe |

## Verification
A clear write and a wrap can fall in the same cycle. The bench provokes this by stepping the divider to 255 and then, on a single cycle, driving the selected tick together with a mode write that has bit 3 set. It judges the outcome one cycle later: the count and flag must both be 0, and none of the request, wake or timeout strobes may appear. A second collision is a wrap that meets a flag already set. The bench checks it by letting the divider wrap twice with no clear in between, and it expects the timeout strobe only on the second wrap.

// File: rtl/bit_pkg.sv
package bit_pkg;

    localparam int CNT_W    = 8;
    localparam int NUM_TAPS = 4;
    localparam int SEL_W    = 3;
    localparam int MODE_W   = SEL_W + 1;

    typedef logic [SEL_W-1:0] sel_code_t;

    // Selector code that enables each tick input, index 0 = fastest tap.
    localparam sel_code_t TAP_CODE [NUM_TAPS] = '{3'b111, 3'b101, 3'b011, 3'b000};

    typedef struct packed {
        logic flag;
        logic req;
        logic wake;
        logic wdt;
    } irq_out_t;

endpackage

// File: rtl/bit_tap_sel.sv
module bit_tap_sel
    import bit_pkg::*;
#(
    parameter int NT = NUM_TAPS
) (
    input  logic          clk,
    input  logic          rst,
    input  sel_code_t     code,
    input  logic [NT-1:0] taps,
    output logic          tick
);

    logic [NT-1:0] hit;

    for (genvar i = 0; i < NT; i++) begin : g_tap
        assign hit[i] = (code == TAP_CODE[i]) && taps[i];
    end

    assign tick = |hit;

    AST_TICK_NEEDS_TAP: assert property (@(posedge clk) disable iff (rst)
        tick |-> (|taps)); // R4

endmodule

// File: rtl/bit_divider.sv
module bit_divider #(
    parameter int W = bit_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    // Wrap strobe; a clear in the same cycle suppresses it.
    assign ovf = tick && (&cnt) && !clr;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (cnt == W'($past(cnt) + 1'b1))); // R4

endmodule

// File: rtl/bit_irq_flag.sv
module bit_irq_flag
    import bit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ovf,
    input  logic     clr,
    output irq_out_t irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= '0;
        end else begin
            irq.req  <= ovf;
            irq.wake <= ovf;
            irq.wdt  <= ovf && irq.flag;
            if (clr)      irq.flag <= 1'b0;
            else if (ovf) irq.flag <= 1'b1;
        end
    end

    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq.req |-> irq.flag); // R5
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!irq.flag && !irq.req && !irq.wdt)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq.flag && !clr) |=> irq.flag); // R11

endmodule

// File: rtl/bit_timer.sv
module bit_timer
    import bit_pkg::*;
#(
    parameter int CW = bit_pkg::CNT_W,
    parameter int NT = bit_pkg::NUM_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NT-1:0]     tap_tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_rdata,
    output logic [CW-1:0]     count_q,
    output logic              irq_flag,
    output logic              irq_req,
    output logic              wait_release,
    output logic              wdt_timeout
);

    sel_code_t sel_q;
    logic      clr;
    logic      tick;
    logic      ovf;
    irq_out_t  irq;

    assign clr = mode_we && mode_wdata[MODE_W-1];

    always_ff @(posedge clk) begin
        if (rst)          sel_q <= '0;
        else if (mode_we) sel_q <= mode_wdata[SEL_W-1:0];
    end

    bit_tap_sel #(.NT(NT)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .code (sel_q),
        .taps (tap_tick),
        .tick (tick)
    );

    bit_divider #(.W(CW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clr  (clr),
        .cnt  (count_q),
        .ovf  (ovf)
    );

    bit_irq_flag u_irq (
        .clk (clk),
        .rst (rst),
        .ovf (ovf),
        .clr (clr),
        .irq (irq)
    );

    assign mode_rdata   = {1'b0, sel_q};
    assign irq_flag     = irq.flag;
    assign irq_req      = irq.req;
    assign wait_release = irq.wake;
    assign wdt_timeout  = irq.wdt;

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (count_q == '0)); // R5
    AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req); // R5
    AST_WAKE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        wait_release |-> (count_q == '0)); // R6
    AST_WDT_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        wdt_timeout |-> irq_req); // R10

endmodule

// File: tb/tb_bit_timer.sv
module tb_bit_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tap_tick = '0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic [3:0] mode_rdata;
    logic [7:0] count_q;
    logic       irq_flag, irq_req, wait_release, wdt_timeout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_timer dut (
        .clk          (clk),
        .rst          (rst),
        .tap_tick     (tap_tick),
        .mode_we      (mode_we),
        .mode_wdata   (mode_wdata),
        .mode_rdata   (mode_rdata),
        .count_q      (count_q),
        .irq_flag     (irq_flag),
        .irq_req      (irq_req),
        .wait_release (wait_release),
        .wdt_timeout  (wdt_timeout)
    );

    typedef struct packed {
        logic [2:0] code;
        logic [3:0] mask;
        logic [7:0] n;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        {3'b000, 4'b1000, 8'd5,  8'd5},
        {3'b000, 4'b0111, 8'd5,  8'd0},
        {3'b011, 4'b0100, 8'd7,  8'd7},
        {3'b011, 4'b1011, 8'd6,  8'd0},
        {3'b101, 4'b0010, 8'd9,  8'd9},
        {3'b111, 4'b0001, 8'd12, 8'd12},
        {3'b010, 4'b1111, 8'd4,  8'd0},
        {3'b110, 4'b1111, 8'd3,  8'd0},
        {3'b001, 4'b1111, 8'd2,  8'd0},
        {3'b111, 4'b1111, 8'd20, 8'd20}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [3:0] d);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = d;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic tick(input logic [3:0] m);
        @(negedge clk);
        tap_tick = m;
        @(negedge clk);
        tap_tick = '0;
    endtask

    task automatic ticks(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) tick(m);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", count_q, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 pulses", {irq_req, wait_release, wdt_timeout}, 0);
        check("R1 mode", mode_rdata, 0);
        rst = 1'b0;
        tick(4'b1000);
        check("R1 reset selects slowest tap", count_q, 1);

        // R2, R3, R4: tap selection table
        for (int i = 0; i < NV; i++) begin
            write_mode({1'b1, VECS[i].code});
            ticks(VECS[i].mask, int'(VECS[i].n));
            check("R2,R3,R4 table count", count_q, VECS[i].exp);
            check("R3 table flag", irq_flag, 0);
        end

        // R9: readback, bit 3 reads 0
        write_mode(4'b1101);
        check("R9 readback", mode_rdata, 4'b0101);
        // R7: write without bit 3 keeps count
        ticks(4'b0010, 3);
        write_mode(4'b0111);
        check("R7 no clear keeps count", count_q, 3);
        check("R9 selector updated", mode_rdata, 4'b0111);

        // R5, R6, R10: first wrap
        write_mode(4'b1111);
        ticks(4'b0001, 255);
        check("R5 at top", count_q, 255);
        check("R5 no early flag", irq_flag, 0);
        tick(4'b0001);
        check("R5 wrap count", count_q, 0);
        check("R5 flag set", irq_flag, 1);
        check("R5 req pulse", irq_req, 1);
        check("R6 wake pulse", wait_release, 1);
        check("R10 no timeout on first wrap", wdt_timeout, 0);
        @(negedge clk);
        check("R5 req one cycle", irq_req, 0);
        check("R6 wake one cycle", wait_release, 0);
        check("R11 flag sticky", irq_flag, 1);

        // R10: second wrap with flag still set
        ticks(4'b0001, 255);
        check("R11 flag held", irq_flag, 1);
        check("R10 no early timeout", wdt_timeout, 0);
        tick(4'b0001);
        check("R10 timeout pulse", wdt_timeout, 1);
        check("R10 req with timeout", irq_req, 1);
        @(negedge clk);
        check("R10 timeout one cycle", wdt_timeout, 0);

        // R7: clear with flag set
        ticks(4'b0001, 4);
        write_mode(4'b1111);
        check("R7 clear count", count_q, 0);
        check("R7 clear flag", irq_flag, 0);

        // R8: clear and wrap in the same cycle
        ticks(4'b0001, 255);
        check("R8 at top", count_q, 255);
        @(negedge clk);
        tap_tick = 4'b0001;
        mode_we = 1'b1;
        mode_wdata = 4'b1111;
        @(negedge clk);
        tap_tick = '0;
        mode_we = 1'b0;
        check("R8 count cleared", count_q, 0);
        check("R8 flag clear", irq_flag, 0);
        check("R8 no pulses", {irq_req, wait_release, wdt_timeout}, 0);

        finish_run();
    end

endmodule